// File: doc/BRIEF.md
# Cartridge memory bank controller

This block sits between an 8-bit CPU bus with a 16-bit address space and the external ROM and RAM devices of a cartridge. CPU writes that land in the lower half of the address space (the ROM area) do not reach any memory. They are decoded as updates to four small control registers: a RAM enable flag, a 5-bit low ROM bank field, a 2-bit upper field, and a banking mode bit.

From those registers the block turns every CPU access into a physical address and a chip select. The address space is split as follows:

- 0x0000–0x3FFF is a fixed 16 KiB ROM area.
- 0x4000–0x7FFF is a switchable 16 KiB ROM window.
- 0xA000–0xBFFF is an 8 KiB window into external RAM.

The mode bit decides where the 2-bit upper field goes. It either extends the ROM bank number or selects the RAM bank.

The read data path is merged here as well. ROM data is returned for ROM reads and RAM data for enabled RAM reads. The block returns 0xFF in every other case. All address and select outputs are combinational from the current address and register state. A register write takes effect on the clock edge that ends the write cycle.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF with data 0x0A sets the RAM enable flag, data 0x00 clears it, and any other data leaves it unchanged.
- R2: A write to 0x2000–0x3FFF loads data bits [4:0] into the low bank field, loading 1 when the whole data byte is 0x00. A low field value of 0 (for example after writing 0x20) is used as 1 when forming the window bank.
- R3: A write to 0x4000–0x5FFF loads data bits [1:0] into the 2-bit upper field.
- R4: A write to 0x6000–0x7FFF sets the banking mode from data bit 0 alone. 0 means ROM-banking mode and 1 means RAM-banking mode; other bits are ignored without any error.
- R5: A read of 0x0000–0x3FFF asserts rom_sel with rom_addr equal to the CPU address, whatever the bank registers hold.
- R6: In ROM-banking mode, a read of 0x4000–0x7FFF gives rom_addr = bank × 0x4000 + (address − 0x4000), where bank = upper field × 32 + effective low field.
- R7: In RAM-banking mode, the window bank is the effective low field alone, so rom_addr bits [20:19] are 0.
- R8: An access to 0xA000–0xBFFF gives ram_addr = ram bank × 0x2000 + (address − 0xA000). The RAM bank is 0 in ROM-banking mode and equals the upper field in RAM-banking mode.
- R9: ram_sel is asserted for reads or writes of 0xA000–0xBFFF only while RAM is enabled, and ram_we only for such writes. A read of the RAM window while RAM is disabled returns 0xFF on cpu_rdata.
- R10: After reset, RAM is disabled, the mode is ROM-banking, the upper field is 0, and window reads use bank 1.
- R11: rom_sel is asserted only for reads of 0x0000–0x7FFF. Writes there assert neither rom_sel nor ram_sel. Accesses outside the ROM and RAM windows select nothing, and reads there return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_addr | output | 15 | Physical RAM byte address |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |

## Verification
The bench targets the zero-bank substitution in three forms: a write of 0x00, a write of 0x20 whose low bits are zero, and the state after reset. A design that got it wrong would map the window onto the fixed area, giving bank 0 or bank 0x20 addresses.

It also flips the mode while the upper field holds 3. A design that steered the 2-bit field the wrong way would leak into rom_addr[20:19] in RAM-banking mode, or would bank RAM in ROM-banking mode.

Writes of non-command values to the enable range and mode values above 1 check that the flag holds and that only bit 0 counts. With RAM disabled, reads and writes of the RAM window must not assert ram_sel or ram_we, and the read must return 0xFF.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    // Base widths
    localparam int CPU_AW  = 16;
    localparam int DW      = 8;
    localparam int LOW_W   = 5;
    localparam int HIGH_W  = 2;
    localparam int ROMWIN_W = 14;  // 16 KiB ROM window
    localparam int RAMWIN_W = 13;  // 8 KiB RAM window

    // Derived widths
    localparam int BANK_W = LOW_W + HIGH_W;
    localparam int ROM_AW = ROMWIN_W + BANK_W;
    localparam int RAM_AW = RAMWIN_W + HIGH_W;

    // Command codes for the RAM enable range
    localparam logic [DW-1:0] CMD_RAM_ON  = 8'h0A;
    localparam logic [DW-1:0] CMD_RAM_OFF = 8'h00;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_ROM_FIXED,
        RG_ROM_WIN,
        RG_RAM
    } region_e;

    typedef enum logic [2:0] {
        WT_NONE,
        WT_RAM_EN,
        WT_LOW,
        WT_HIGH,
        WT_MODE
    } wtarget_e;

    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_RAM = 1'b1
    } bank_mode_e;

    typedef struct packed {
        logic              ram_en;
        logic [LOW_W-1:0]  low;
        logic [HIGH_W-1:0] high;
        bank_mode_e        mode;
    } bank_state_t;

    function automatic region_e region_of(input logic [CPU_AW-1:0] a);
        if (a[15:14] == 2'b00)      return RG_ROM_FIXED;
        else if (a[15:14] == 2'b01) return RG_ROM_WIN;
        else if (a[15:13] == 3'b101) return RG_RAM;
        else                        return RG_NONE;
    endfunction

    // A low field of zero always acts as bank 1
    function automatic logic [LOW_W-1:0] low_effective(input logic [LOW_W-1:0] v);
        return (v == '0) ? LOW_W'(1) : v;
    endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic              wr,
    output region_e           region,
    output wtarget_e          wtarget
);

    always_comb begin
        region  = region_of(addr);
        wtarget = WT_NONE;
        if (wr && !addr[15]) begin
            unique case (addr[14:13])
                2'b00: wtarget = WT_RAM_EN;
                2'b01: wtarget = WT_LOW;
                2'b10: wtarget = WT_HIGH;
                2'b11: wtarget = WT_MODE;
            endcase
        end
    end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wtarget_e      wtarget,
    input  logic [DW-1:0] wdata,
    output bank_state_t   state
);

    bank_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (wtarget)
            WT_RAM_EN: begin
                if (wdata == CMD_RAM_ON)       nxt.ram_en = 1'b1;
                else if (wdata == CMD_RAM_OFF) nxt.ram_en = 1'b0;
            end
            WT_LOW:  nxt.low  = (wdata == '0) ? LOW_W'(1) : wdata[LOW_W-1:0];
            WT_HIGH: nxt.high = wdata[HIGH_W-1:0];
            WT_MODE: nxt.mode = bank_mode_e'(wdata[0]);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state.ram_en <= 1'b0;
            state.low    <= '0;
            state.high   <= '0;
            state.mode   <= MODE_ROM;
        end else begin
            state <= nxt;
        end
    end

    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (wtarget == WT_RAM_EN && wdata == CMD_RAM_ON) |=> state.ram_en);  // R1
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wtarget == WT_RAM_EN && wdata != CMD_RAM_ON && wdata != CMD_RAM_OFF)
        |=> $stable(state.ram_en));  // R1
    AST_LOW_ZERO_FIX: assert property (@(posedge clk) disable iff (rst)
        (wtarget == WT_LOW && wdata == '0) |=> (state.low == LOW_W'(1)));  // R2
    AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wtarget == WT_HIGH) |=> (state.high == $past(wdata[HIGH_W-1:0])));  // R3
    AST_MODE_BIT0: assert property (@(posedge clk) disable iff (rst)
        (wtarget == WT_MODE) |=> (state.mode == bank_mode_e'($past(wdata[0]))));  // R4

endmodule

// File: rtl/cbc_map.sv
module cbc_map
    import cbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bank_state_t         state,
    input  region_e             region,
    input  logic [ROMWIN_W-1:0] offs,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic [RAM_AW-1:0]   ram_addr
);

    logic [LOW_W-1:0]  low_eff;
    logic [BANK_W-1:0] rom_bank;
    logic [HIGH_W-1:0] ram_bank;

    always_comb begin
        low_eff  = low_effective(state.low);
        rom_bank = (state.mode == MODE_ROM) ? {state.high, low_eff}
                                            : {{HIGH_W{1'b0}}, low_eff};
        ram_bank = (state.mode == MODE_RAM) ? state.high : '0;
        if (region == RG_ROM_WIN)
            rom_addr = {rom_bank, offs};
        else
            rom_addr = {{BANK_W{1'b0}}, offs};
        ram_addr = {ram_bank, offs[RAMWIN_W-1:0]};
    end

    AST_WIN_NOT_FIXED: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ROM_WIN) |-> (rom_addr[ROM_AW-1:ROMWIN_W] != '0));  // R2
    AST_RAMMODE_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ROM_WIN && state.mode == MODE_RAM)
        |-> (rom_addr[ROM_AW-1:ROM_AW-HIGH_W] == '0));  // R7
    AST_ROMMODE_RAM0: assert property (@(posedge clk) disable iff (rst)
        (state.mode == MODE_ROM) |-> (ram_addr[RAM_AW-1:RAMWIN_W] == '0));  // R8

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DW-1:0]     rom_rdata,
    input  logic [DW-1:0]     ram_rdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              rom_sel,
    output logic              ram_sel,
    output logic              ram_we
);

    region_e     region;
    wtarget_e    wtarget;
    bank_state_t state;
    logic        rom_area;

    cbc_decode u_decode (
        .addr    (cpu_addr),
        .wr      (cpu_wr),
        .region  (region),
        .wtarget (wtarget)
    );

    cbc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wtarget (wtarget),
        .wdata   (cpu_wdata),
        .state   (state)
    );

    cbc_map u_map (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .region   (region),
        .offs     (cpu_addr[ROMWIN_W-1:0]),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr)
    );

    always_comb begin
        rom_area  = (region == RG_ROM_FIXED) || (region == RG_ROM_WIN);
        rom_sel   = cpu_rd && rom_area;
        ram_sel   = (cpu_rd || cpu_wr) && (region == RG_RAM) && state.ram_en;
        ram_we    = cpu_wr && (region == RG_RAM) && state.ram_en;
        if (rom_sel)              cpu_rdata = rom_rdata;
        else if (ram_sel && cpu_rd) cpu_rdata = ram_rdata;
        else                      cpu_rdata = 8'hFF;
    end

    AST_FIXED_IDENT: assert property (@(posedge clk) disable iff (rst)
        (rom_sel && cpu_addr[15:14] == 2'b00)
        |-> (rom_addr == ROM_AW'(cpu_addr)));  // R5
    AST_RAM_GATED: assert property (@(posedge clk) disable iff (rst)
        ram_sel |-> state.ram_en);  // R9
    AST_WE_IN_SEL: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_sel && cpu_wr));  // R9
    AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, ram_sel}));  // R11
    AST_ROM_WR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_rd && !cpu_addr[15]) |-> (!rom_sel && !ram_sel));  // R11

endmodule

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata, ram_rdata, cpu_rdata;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        rom_sel, ram_sel, ram_we;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] romf(input logic [20:0] a);
        return a[7:0] ^ a[20:13];
    endfunction
    function automatic logic [7:0] ramf(input logic [14:0] a);
        return (a[7:0] ^ {1'b0, a[14:8]}) + 8'h5A;
    endfunction

    assign rom_rdata = romf(rom_addr);
    assign ram_rdata = ramf(ram_addr);

    cart_bank_ctrl i_cart_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
        .ram_addr(ram_addr), .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we)
    );

    typedef struct {
        logic        rs, ms, we;
        logic [7:0]  rd;
        logic        chk_rom, chk_ram;
        logic [20:0] rom_a;
        logic [14:0] ram_a;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    // Reference register state, kept from the requirements
    logic       m_en = 1'b0;
    logic [4:0] m_low = 5'd0;
    logic [1:0] m_high = 2'd0;
    logic       m_mode = 1'b0;

    function automatic exp_t predict(input logic [15:0] a, input logic rd,
                                     input logic wr, input string tag);
        exp_t e;
        logic [4:0] leff;
        logic [6:0] bank;
        logic [1:0] rbank;
        logic in_ram;
        leff   = (m_low == 0) ? 5'd1 : m_low;
        bank   = m_mode ? {2'b00, leff} : {m_high, leff};
        rbank  = m_mode ? m_high : 2'b00;
        in_ram = (a[15:13] == 3'b101);
        e.tag     = tag;
        e.chk_rom = rd && !a[15];
        e.chk_ram = in_ram;
        e.rom_a   = a[14] ? {bank, a[13:0]} : {7'd0, a[13:0]};
        e.ram_a   = {rbank, a[12:0]};
        e.rs      = rd && !a[15];
        e.ms      = (rd || wr) && in_ram && m_en;
        e.we      = wr && in_ram && m_en;
        if (e.rs)              e.rd = romf(e.rom_a);
        else if (e.ms && rd)   e.rd = ramf(e.ram_a);
        else                   e.rd = 8'hFF;
        return e;
    endfunction

    task automatic access(input logic [15:0] a, input logic [7:0] d,
                          input logic rd, input logic wr, input string tag);
        @(posedge clk); #1;
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        sbq.push_back(predict(a, rd, wr, tag));
        if (wr && !a[15]) begin
            case (a[14:13])
                2'b00: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
                2'b01: m_low = (d == 8'h00) ? 5'd1 : d[4:0];
                2'b10: m_high = d[1:0];
                2'b11: m_mode = d[0];
            endcase
        end
    endtask

    task automatic rd_(input logic [15:0] a, input string tag);
        access(a, 8'h00, 1'b1, 1'b0, tag);
    endtask
    task automatic wr_(input logic [15:0] a, input logic [7:0] d, input string tag);
        access(a, d, 1'b0, 1'b1, tag);
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares one expected item per cycle, mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, "rom_sel", 32'(rom_sel), 32'(e.rs));
                check(e.tag, "ram_sel", 32'(ram_sel), 32'(e.ms));
                check(e.tag, "ram_we",  32'(ram_we),  32'(e.we));
                check(e.tag, "cpu_rdata", 32'(cpu_rdata), 32'(e.rd));
                if (e.chk_rom) check(e.tag, "rom_addr", 32'(rom_addr), 32'(e.rom_a));
                if (e.chk_ram) check(e.tag, "ram_addr", 32'(ram_addr), 32'(e.ram_a));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R10: reset state
        rd_(16'h4000, "R10 window bank 1");
        rd_(16'hA000, "R10 RAM disabled");
        rd_(16'h0123, "R5 fixed area");
        // R2 / R6
        wr_(16'h2000, 8'h05, "R11 low write quiet");
        rd_(16'h4001, "R6 bank 5");
        wr_(16'h2100, 8'h00, "R2 zero write");
        rd_(16'h7FFF, "R2 zero gives bank 1");
        wr_(16'h3000, 8'h20, "R2 write 0x20");
        rd_(16'h4000, "R2 low zero acts as 1");
        wr_(16'h2000, 8'hFF, "R2 low 1F");
        wr_(16'h4000, 8'h03, "R3 upper 3");
        rd_(16'h5555, "R6 bank 7F");
        rd_(16'h3FFF, "R5 fixed ignores banks");
        // R1 / R8 / R9
        wr_(16'h0000, 8'h0A, "R1 enable");
        rd_(16'hA010, "R8 ROM mode RAM bank 0");
        wr_(16'hB234, 8'h77, "R9 RAM write");
        // R4 / R7
        wr_(16'h6000, 8'h01, "R4 RAM mode");
        rd_(16'h5555, "R7 no upper bits");
        rd_(16'hBFFF, "R8 RAM bank 3");
        wr_(16'h1000, 8'h55, "R1 other value");
        rd_(16'hA000, "R1 enable held");
        wr_(16'h4000, 8'hFE, "R3 upper 2");
        rd_(16'hA123, "R8 RAM bank 2");
        wr_(16'h7000, 8'h02, "R4 bit0 zero");
        rd_(16'h4ABC, "R4 ROM mode again");
        wr_(16'h7FFF, 8'h03, "R4 bit0 one");
        rd_(16'h4ABC, "R7 RAM mode again");
        wr_(16'h0000, 8'h00, "R1 disable");
        wr_(16'hA000, 8'h11, "R9 write blocked");
        rd_(16'hA000, "R9 disabled read FF");
        rd_(16'hC000, "R11 outside windows");
        wr_(16'hD000, 8'h0A, "R11 write outside");
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule